// File: doc/BRIEF.md
# DMA Channel Request Arbiter with Poll and Priority Modes

This block decides which of several DMA channels may issue its next bus burst. There are two independent arbitration lanes, one for read requests and one for write requests. Each lane has its own per-channel request lines, its own per-channel priority codes and its own completion input. When a lane is idle and at least one channel requests, the lane registers a one-hot grant together with a valid strobe. The grant stays with that channel until the channel reports the end of its burst on the lane's done input.

Each channel's 5-bit priority code selects one of two modes. With the top bit set, the channel takes part in plain rotating (poll) arbitration. With the top bit clear, the low four bits give a quality-of-service level from 0 to 15, and a larger value wins. Channels in priority mode always beat channels in poll mode. Among equal candidates, the search starts just after the most recently granted channel and rotates.

Top module: `dma_req_arbiter`

## Requirements
- R1: While `rst` is high, and on the first sample after it, both lanes show a zero grant vector and a low valid strobe.
- R2: Whenever a lane's valid strobe is high, its grant vector has exactly one bit set. Whenever the strobe is low, the grant vector is all zero.
- R3: A lane that is idle on a clock edge, and sees at least one request on that edge, shows valid high with the new grant after that edge.
- R4: While a grant is held and done is low, the grant vector and the strobe stay unchanged, whatever happens to requests or priority codes.
- R5: A done pulse sampled while a grant is held drops the valid strobe on the next edge. The lane then stays idle for that cycle before it grants again.
- R6: Code bit 4 set (code value 5'h10 to 5'h1F) selects poll mode. If no requesting channel is in priority mode, the grant goes to the first requesting channel found when searching upward, with wrap-around, from the channel after the last one granted. Channels that are not requesting are skipped. After reset, the search starts at channel 0.
- R7: Code bit 4 clear selects priority mode, with bits 3:0 as the level (0 to 15). Among requesting priority-mode channels, one with the highest level is granted.
- R8: When several requesting priority-mode channels share the highest level, the tie is broken by the same rotating search as in R6, applied only to those tied channels.
- R9: If any requesting channel is in priority mode, no poll-mode channel is granted, even when its level bits are higher.
- R10: The read and write lanes are independent. Requests, codes and done pulses on one lane never change the grant or strobe of the other.
- R11: A done pulse on an idle lane has no effect.
- R12: A lane grants only a channel whose request was high on the arbitration edge. With no requests, the lane stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | NCH | Per-channel read request |
| rd_code | input | 5*NCH | Read priority codes, channel i in bits 5i+4:5i |
| rd_done | input | 1 | Burst complete from the granted read channel |
| rd_gnt | output | NCH | One-hot read grant |
| rd_gnt_vld | output | 1 | Read grant valid |
| wr_req | input | NCH | Per-channel write request |
| wr_code | input | 5*NCH | Write priority codes, same layout as rd_code |
| wr_done | input | 1 | Burst complete from the granted write channel |
| wr_gnt | output | NCH | One-hot write grant |
| wr_gnt_vld | output | 1 | Write grant valid |

## Verification
A grant is due one edge after an idle cycle with requests, so it is sampled at the falling edge after inputs were applied. A release is due one edge after done, so the strobe is checked low at the next falling edge. The bench drives every input on a falling edge. A behavioural model updates on the rising edge from those same inputs and is compared with both lanes at every falling edge. Explicit checks of the expected grant order, hold stability and lane independence are sampled at those same points.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    localparam int CODE_W = 5;
    localparam int LVL_W  = 4;

    // Per-channel priority code: poll flag on top, level underneath
    typedef struct packed {
        logic             poll;
        logic [LVL_W-1:0] lvl;
    } prio_code_t;

    function automatic logic in_qos(input prio_code_t c);
        return !c.poll;
    endfunction

endpackage

// File: rtl/arb_select.sv
module arb_select
    import dma_arb_pkg::*;
#(
    parameter int NCH = 4,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0]         req,
    input  prio_code_t [NCH-1:0]   codes,
    input  logic [IW-1:0]          last,
    output logic                   pick_vld,
    output logic [IW-1:0]          pick_idx
);

    logic             any_qos;
    logic [LVL_W-1:0] top_lvl;
    logic [NCH-1:0]   cand;

    // Highest level among requesting priority-mode channels
    always_comb begin
        any_qos = 1'b0;
        top_lvl = '0;
        for (int i = 0; i < NCH; i++) begin
            if (req[i] && in_qos(codes[i])) begin
                any_qos = 1'b1;
                if (codes[i].lvl > top_lvl) top_lvl = codes[i].lvl;
            end
        end
    end

    // Candidate set: top-level priority requesters, else all requesters
    generate
        for (genvar g = 0; g < NCH; g++) begin : g_cand
            assign cand[g] = req[g] &&
                (any_qos ? (in_qos(codes[g]) && codes[g].lvl == top_lvl) : 1'b1);
        end
    endgenerate

    // Rotating search starting after the last grant
    always_comb begin
        pick_vld = 1'b0;
        pick_idx = last;
        for (int k = 1; k <= NCH; k++) begin
            int c;
            c = (int'(last) + k) % NCH;
            if (!pick_vld && cand[c]) begin
                pick_vld = 1'b1;
                pick_idx = IW'(c);
            end
        end
    end

endmodule

// File: rtl/arb_lane.sv
module arb_lane
    import dma_arb_pkg::*;
#(
    parameter int NCH = 4,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NCH-1:0]       req,
    input  prio_code_t [NCH-1:0] codes,
    input  logic                 done,
    output logic [NCH-1:0]       gnt,
    output logic                 gnt_vld
);

    logic          pick_vld;
    logic [IW-1:0] pick_idx;
    logic [IW-1:0] cur_idx;   // granted channel, also rotation pointer

    arb_select #(.NCH(NCH)) u_sel (
        .req      (req),
        .codes    (codes),
        .last     (cur_idx),
        .pick_vld (pick_vld),
        .pick_idx (pick_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_vld <= 1'b0;
            cur_idx <= IW'(NCH - 1);
        end else if (gnt_vld) begin
            if (done) gnt_vld <= 1'b0;
        end else if (pick_vld) begin
            gnt_vld <= 1'b1;
            cur_idx <= pick_idx;
        end
    end

    always_comb begin
        gnt = '0;
        if (gnt_vld) gnt[cur_idx] = 1'b1;
    end

    // R2
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        gnt_vld |-> ($countones(gnt) == 1));
    // R2
    gnt_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !gnt_vld |-> (gnt == '0));
    // R3
    grant_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (!gnt_vld && (|req)) |=> gnt_vld);
    // R4
    gnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (gnt_vld && !done) |=> (gnt_vld && $stable(gnt)));
    // R5
    done_release_chk: assert property (@(posedge clk) disable iff (rst)
        (gnt_vld && done) |=> !gnt_vld);
    // R12
    gnt_to_requester_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gnt_vld) |-> (($past(req) & gnt) != '0));

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NCH-1:0]        rd_req,
    input  logic [CODE_W*NCH-1:0] rd_code,
    input  logic                  rd_done,
    output logic [NCH-1:0]        rd_gnt,
    output logic                  rd_gnt_vld,
    input  logic [NCH-1:0]        wr_req,
    input  logic [CODE_W*NCH-1:0] wr_code,
    input  logic                  wr_done,
    output logic [NCH-1:0]        wr_gnt,
    output logic                  wr_gnt_vld
);

    prio_code_t [NCH-1:0] rd_codes;
    prio_code_t [NCH-1:0] wr_codes;

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_unpack
            assign rd_codes[g] = prio_code_t'(rd_code[g*CODE_W +: CODE_W]);
            assign wr_codes[g] = prio_code_t'(wr_code[g*CODE_W +: CODE_W]);
        end
    endgenerate

    arb_lane #(.NCH(NCH)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .req     (rd_req),
        .codes   (rd_codes),
        .done    (rd_done),
        .gnt     (rd_gnt),
        .gnt_vld (rd_gnt_vld)
    );

    arb_lane #(.NCH(NCH)) u_wr (
        .clk     (clk),
        .rst     (rst),
        .req     (wr_req),
        .codes   (wr_codes),
        .done    (wr_done),
        .gnt     (wr_gnt),
        .gnt_vld (wr_gnt_vld)
    );

endmodule

// File: tb/dma_req_arbiter_test.sv
module dma_req_arbiter_test;

    localparam int N = 4;
    localparam logic [4:0] POLL = 5'h10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] rd_req = '0, wr_req = '0;
    logic rd_done = 1'b0, wr_done = 1'b0;
    logic [4:0] rcfg [N];
    logic [4:0] wcfg [N];
    logic [5*N-1:0] rd_code, wr_code;
    logic [N-1:0] rd_gnt, wr_gnt;
    logic rd_gnt_vld, wr_gnt_vld;

    int n_tests = 0;
    int n_fail  = 0;
    string tag = "R1";

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            rd_code[i*5 +: 5] = rcfg[i];
            wr_code[i*5 +: 5] = wcfg[i];
        end
    end

    dma_req_arbiter #(.NCH(N)) uut (
        .clk(clk), .rst(rst),
        .rd_req(rd_req), .rd_code(rd_code), .rd_done(rd_done),
        .rd_gnt(rd_gnt), .rd_gnt_vld(rd_gnt_vld),
        .wr_req(wr_req), .wr_code(wr_code), .wr_done(wr_done),
        .wr_gnt(wr_gnt), .wr_gnt_vld(wr_gnt_vld)
    );

    // ---------------- behavioural reference ----------------
    int m_vld [2];
    int m_idx [2];

    function automatic int m_pick(input int lane, input int last);
        int best;
        bit have_q;
        logic [4:0] c;
        logic r;
        best = -1;
        have_q = 0;
        for (int i = 0; i < N; i++) begin
            c = (lane == 0) ? rcfg[i] : wcfg[i];
            r = (lane == 0) ? rd_req[i] : wr_req[i];
            if (r && !c[4]) begin
                have_q = 1;
                if (int'(c[3:0]) > best) best = int'(c[3:0]);
            end
        end
        for (int k = 1; k <= N; k++) begin
            int ch;
            ch = (last + k) % N;
            c = (lane == 0) ? rcfg[ch] : wcfg[ch];
            r = (lane == 0) ? rd_req[ch] : wr_req[ch];
            if (r && (!have_q || (!c[4] && int'(c[3:0]) == best))) return ch;
        end
        return -1;
    endfunction

    always @(posedge clk) begin
        for (int l = 0; l < 2; l++) begin
            if (rst) begin
                m_vld[l] = 0;
                m_idx[l] = N - 1;
            end else if (m_vld[l] != 0) begin
                if ((l == 0) ? rd_done : wr_done) m_vld[l] = 0;
            end else begin
                int p;
                p = m_pick(l, m_idx[l]);
                if (p >= 0) begin
                    m_vld[l] = 1;
                    m_idx[l] = p;
                end
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int gvec(input int lane);
        if (m_vld[lane] == 0) return 0;
        return 1 << m_idx[lane];
    endfunction

    // Compare both lanes with the model on every falling edge
    always @(negedge clk) begin
        if (!rst) begin
            check(tag, "rd strobe vs model", int'(rd_gnt_vld), m_vld[0]);
            check(tag, "rd grant vs model",  int'(rd_gnt), gvec(0));
            check(tag, "wr strobe vs model", int'(wr_gnt_vld), m_vld[1]);
            check(tag, "wr grant vs model",  int'(wr_gnt), gvec(1));
        end
    end

    // Serve one read burst: expect grant to channel 'ch' one edge after idle
    task automatic serve(input int ch, input string req);
        logic [N-1:0] saved;
        saved = rd_req;
        @(negedge clk);
        check("R3", "rd strobe one edge after idle request", int'(rd_gnt_vld), 1);
        check(req, "rd granted channel", int'(rd_gnt), 1 << ch);
        // R4: disturb requests and codes while the grant is held
        rd_req = ~saved;
        rcfg[ch] = rcfg[ch] ^ 5'h10;
        @(negedge clk);
        check("R4", "rd grant held under disturbance", int'(rd_gnt), 1 << ch);
        rcfg[ch] = rcfg[ch] ^ 5'h10;
        rd_req = saved;
        @(negedge clk);
        check("R4", "rd grant still held", int'(rd_gnt), 1 << ch);
        rd_done = 1'b1;
        @(negedge clk);
        rd_done = 1'b0;
        check("R5", "rd strobe after done", int'(rd_gnt_vld), 0);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            rcfg[i] = POLL;
            wcfg[i] = POLL;
        end
        @(negedge clk);
        check("R1", "rd strobe in reset", int'(rd_gnt_vld), 0);
        check("R1", "wr grant in reset", int'(wr_gnt), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "rd strobe after reset", int'(rd_gnt_vld), 0);
        check("R1", "rd grant after reset", int'(rd_gnt), 0);

        // R12: no requests, no grant
        tag = "R12";
        repeat (3) @(negedge clk);
        check("R12", "rd idle without requests", int'(rd_gnt_vld), 0);

        // R11: done on idle lane
        tag = "R11";
        rd_done = 1'b1;
        @(negedge clk);
        rd_done = 1'b0;
        @(negedge clk);
        check("R11", "rd idle after stray done", int'(rd_gnt_vld), 0);

        // R6: poll rotation
        tag = "R6";
        rd_req = 4'b1111;
        serve(0, "R6"); serve(1, "R6"); serve(2, "R6"); serve(3, "R6"); serve(0, "R6");
        rd_req = 4'b1010;
        serve(1, "R6"); serve(3, "R6"); serve(1, "R6");

        // R7: highest level wins
        tag = "R7";
        rcfg[0] = 5'd3; rcfg[1] = 5'd9; rcfg[2] = 5'd5; rcfg[3] = 5'd1;
        rd_req = 4'b1111;
        serve(1, "R7"); serve(1, "R7");
        rd_req = 4'b1101;
        serve(2, "R7");

        // R8: tie broken by rotation
        tag = "R8";
        rcfg[0] = 5'd7; rcfg[1] = 5'd7; rcfg[2] = 5'd2; rcfg[3] = 5'd7;
        rd_req = 4'b1111;
        serve(3, "R8"); serve(0, "R8"); serve(1, "R8"); serve(3, "R8");

        // R9: priority mode beats poll mode, even poll with high level bits
        tag = "R9";
        rcfg[0] = 5'h1F; rcfg[1] = 5'd0; rcfg[2] = 5'h1F; rcfg[3] = 5'h1F;
        rd_req = 4'b1111;
        serve(1, "R9"); serve(1, "R9");
        rd_req = 4'b1101;
        serve(2, "R6");
        rd_req = '0;

        // R10: lanes independent
        tag = "R10";
        @(negedge clk);
        wr_req = 4'b0100;
        rd_req = 4'b0001;
        @(negedge clk);
        check("R10", "rd grant", int'(rd_gnt), 4'b0001);
        check("R10", "wr grant", int'(wr_gnt), 4'b0100);
        rd_done = 1'b1;
        @(negedge clk);
        rd_done = 1'b0;
        rd_req = '0;
        check("R10", "rd released", int'(rd_gnt_vld), 0);
        check("R10", "wr unaffected by rd done", int'(wr_gnt), 4'b0100);
        wr_done = 1'b1;
        @(negedge clk);
        wr_done = 1'b0;
        wr_req = '0;
        check("R10", "wr released", int'(wr_gnt_vld), 0);
        check("R2", "rd grant zero when idle", int'(rd_gnt), 0);
        repeat (2) @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 20000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule